// File: doc/BRIEF.md
# Guarded Move Transport Interconnect

This block is the transport network of an exposed-datapath processor. The instruction word carries no operations, only moves. Each parallel transport bus gets its own slot. A slot names a source port, a destination port and an optional guard. In one clock cycle every bus can carry one value from the output of one unit port to the input of another. Function units, register files and instruction fetch sit outside the block. They connect through a flat vector of source-port data and a set of registered destination-port write strobes with data.

A slot can be tied to one of three 1-bit condition registers. When the selected condition, after an optional inversion, is false, that move is squashed and nothing reaches its destination. The three condition registers are themselves move destinations, so a program sets them with ordinary moves. When two live moves land on the same destination in one cycle, the bus with the lowest index wins, and the block flags the clash for one cycle.

Top module: `tport_move_net`

## Requirements
- R1: While reset is asserted, and after its release until the first move executes, `dst_we_o` and `conflict_o` are low, `dst_data_o` is all zero, and all three condition registers read zero.
- R2: Each bus slot is 10 bits wide, and bus b occupies bits [10b+9:10b] of `move_word_i`. Within a slot, bit 9 is valid, bits 8:6 are the source ID, bits 5:3 are the destination ID, bits 2:1 are the guard select and bit 0 is the invert flag. A valid slot with guard select 0 always executes, whatever the invert flag. In the cycle after the sampling edge, `dst_we_o[dst]` is high for exactly that cycle, and the matching data field carries the source's value from that edge.
- R3: A slot with its valid bit clear has no effect on any output or on any condition register, whatever its other fields hold.
- R4: A valid slot with guard select k in 1..3 executes only if condition register k XOR the invert flag equals 1. A squashed move writes nothing, changes no condition register and takes no part in conflicts.
- R5: All buses act in the same cycle, so up to three executing moves to distinct destinations all produce their strobes and data together.
- R6: When two or more executing moves target one destination in the same cycle, the data from the lowest-numbered bus is delivered and `conflict_o` is high for that output cycle.
- R7: Destination IDs 5, 6 and 7 also load condition registers 1, 2 and 3 with bit 0 of the moved value. Moves sampled at the following edge or later see the new value; moves sampled at the same edge still see the old one. The destination port strobe fires as usual.
- R8: A destination port that is not written in a cycle keeps its last delivered data and has its strobe low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| move_word_i | input | NUM_BUS*10 | One move slot per bus |
| src_data_i | input | 8*DATA_W | Values presented by the eight source ports, port s at [s*DATA_W +: DATA_W] |
| dst_we_o | output | 8 | Registered one-cycle write strobe per destination port |
| dst_data_o | output | 8*DATA_W | Registered data per destination port |
| conflict_o | output | 1 | Registered flag: two or more executing moves hit one destination |

## Verification
The bench builds the block with its defaults: three buses and 16-bit data. With IDs this small, every combination of bus, source and destination can be swept for unguarded moves. Every one of the eight condition-register patterns can then be paired with each guard select, invert flag and bus. Collisions are driven on every destination for every bus pair and for all three buses, including cases where the lower bus is squashed. A long pseudo-random run then mixes guard writes, squashes and clashes against a cycle-level model kept in the bench.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  localparam int SRC_CNT    = 8;
  localparam int DST_CNT    = 8;
  localparam int GUARD_CNT  = 3;
  localparam int SRC_ID_W   = $clog2(SRC_CNT);
  localparam int DST_ID_W   = $clog2(DST_CNT);
  localparam int GSEL_W     = $clog2(GUARD_CNT + 1);
  localparam int GUARD_BASE = DST_CNT - GUARD_CNT;

  typedef struct packed {
    logic                vld;
    logic [SRC_ID_W-1:0] src;
    logic [DST_ID_W-1:0] dst;
    logic [GSEL_W-1:0]   gsel;
    logic                ginv;
  } move_slot_t;

  localparam int SLOT_W = $bits(move_slot_t);
endpackage

// File: rtl/tpm_slot_decode.sv
module tpm_slot_decode
  import tpm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  move_slot_t                  slot_i,
  input  logic [GUARD_CNT-1:0]        guard_i,
  input  logic [SRC_CNT*DATA_W-1:0]   src_data_i,
  output logic                        live_o,
  output logic [DST_ID_W-1:0]         dst_o,
  output logic [DATA_W-1:0]           data_o
);
  logic pass;

  // guard select 0 is unconditional; k selects condition register k
  always_comb begin
    pass = (slot_i.gsel == '0);
    for (int k = 1; k <= GUARD_CNT; k++) begin
      if (slot_i.gsel == GSEL_W'(k)) pass = guard_i[k-1] ^ slot_i.ginv;
    end
    live_o = slot_i.vld & pass;
  end

  assign dst_o  = slot_i.dst;
  assign data_o = src_data_i[slot_i.src*DATA_W +: DATA_W];
endmodule

// File: rtl/tpm_dst_socket.sv
module tpm_dst_socket
  import tpm_pkg::*;
#(
  parameter int NUM_BUS = 3,
  parameter int DATA_W  = 16,
  parameter int DST_IDX = 0
) (
  input  logic [NUM_BUS-1:0]          live_i,
  input  logic [NUM_BUS*DST_ID_W-1:0] dst_i,
  input  logic [NUM_BUS*DATA_W-1:0]   data_i,
  output logic                        hit_o,
  output logic [DATA_W-1:0]           data_o,
  output logic                        multi_o
);
  logic              hit;
  logic              multi;
  logic [DATA_W-1:0] data;

  // lowest bus index claims the port; any later claimant marks a clash
  always_comb begin
    hit   = 1'b0;
    multi = 1'b0;
    data  = '0;
    for (int b = 0; b < NUM_BUS; b++) begin
      if (live_i[b] && (dst_i[b*DST_ID_W +: DST_ID_W] == DST_ID_W'(DST_IDX))) begin
        if (hit) begin
          multi = 1'b1;
        end else begin
          hit  = 1'b1;
          data = data_i[b*DATA_W +: DATA_W];
        end
      end
    end
  end

  assign hit_o   = hit;
  assign data_o  = data;
  assign multi_o = multi;
endmodule

// File: rtl/tpm_guard_bank.sv
module tpm_guard_bank
  import tpm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [GUARD_CNT-1:0] wr_en_i,
  input  logic [GUARD_CNT-1:0] wr_bit_i,
  output logic [GUARD_CNT-1:0] guard_o
);
  logic [GUARD_CNT-1:0] guard_q;
  logic [GUARD_CNT-1:0] guard_d;

  always_comb begin
    for (int g = 0; g < GUARD_CNT; g++) begin
      guard_d[g] = wr_en_i[g] ? wr_bit_i[g] : guard_q[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) guard_q <= '0;
    else        guard_q <= guard_d;
  end

  assign guard_o = guard_q;

  // R7: condition registers change only when written
  a_r7_guard_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i == '0) |=> $stable(guard_q));

  for (genvar g = 0; g < GUARD_CNT; g++) begin : g_chk
    a_r7_guard_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i[g] |=> (guard_q[g] == $past(wr_bit_i[g])));
  end
endmodule

// File: rtl/tport_move_net.sv
module tport_move_net
  import tpm_pkg::*;
#(
  parameter int NUM_BUS = 3,
  parameter int DATA_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BUS*SLOT_W-1:0]   move_word_i,
  input  logic [SRC_CNT*DATA_W-1:0]   src_data_i,
  output logic [DST_CNT-1:0]          dst_we_o,
  output logic [DST_CNT*DATA_W-1:0]   dst_data_o,
  output logic                        conflict_o
);
  localparam int PORT_DW = DST_CNT * DATA_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // per-bus slot decode
  move_slot_t                  slot [NUM_BUS];
  logic [NUM_BUS-1:0]          bus_live;
  logic [NUM_BUS*DST_ID_W-1:0] bus_dst;
  logic [NUM_BUS*DATA_W-1:0]   bus_data;
  logic [GUARD_CNT-1:0]        guard;

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    assign slot[b] = move_slot_t'(move_word_i[b*SLOT_W +: SLOT_W]);
    tpm_slot_decode #(.DATA_W(DATA_W)) u_dec (
      .slot_i     (slot[b]),
      .guard_i    (guard),
      .src_data_i (src_data_i),
      .live_o     (bus_live[b]),
      .dst_o      (bus_dst[b*DST_ID_W +: DST_ID_W]),
      .data_o     (bus_data[b*DATA_W +: DATA_W])
    );
  end

  // per-destination sockets
  logic [DST_CNT-1:0] port_hit;
  logic [DST_CNT-1:0] port_multi;
  logic [PORT_DW-1:0] port_data;

  for (genvar d = 0; d < DST_CNT; d++) begin : g_dst
    tpm_dst_socket #(.NUM_BUS(NUM_BUS), .DATA_W(DATA_W), .DST_IDX(d)) u_sock (
      .live_i  (bus_live),
      .dst_i   (bus_dst),
      .data_i  (bus_data),
      .hit_o   (port_hit[d]),
      .data_o  (port_data[d*DATA_W +: DATA_W]),
      .multi_o (port_multi[d])
    );
  end

  // condition registers share the top destination IDs
  logic [GUARD_CNT-1:0] g_wr_en;
  logic [GUARD_CNT-1:0] g_wr_bit;

  for (genvar g = 0; g < GUARD_CNT; g++) begin : g_gw
    assign g_wr_en[g]  = port_hit[GUARD_BASE+g];
    assign g_wr_bit[g] = port_data[(GUARD_BASE+g)*DATA_W];
  end

  tpm_guard_bank u_guards (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en_i  (g_wr_en),
    .wr_bit_i (g_wr_bit),
    .guard_o  (guard)
  );

  // output registers: next-state then storage
  logic [DST_CNT-1:0] we_d,   we_q;
  logic [PORT_DW-1:0] data_d, data_q;
  logic               conf_d, conf_q;

  always_comb begin
    we_d   = port_hit;
    conf_d = |port_multi;
    for (int d = 0; d < DST_CNT; d++) begin
      data_d[d*DATA_W +: DATA_W] = port_hit[d] ? port_data[d*DATA_W +: DATA_W]
                                               : data_q[d*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      we_q   <= '0;
      data_q <= '0;
      conf_q <= 1'b0;
    end else begin
      we_q   <= we_d;
      data_q <= data_d;
      conf_q <= conf_d;
    end
  end

  assign dst_we_o   = we_q;
  assign dst_data_o = data_q;
  assign conflict_o = conf_q;

  // checks at the block edge
  logic                any_vld;
  logic                b0_uncond;
  logic [DST_ID_W-1:0] b0_dst;
  logic [DATA_W-1:0]   b0_src_val;

  always_comb begin
    any_vld = 1'b0;
    for (int b = 0; b < NUM_BUS; b++) any_vld = any_vld | slot[b].vld;
  end
  assign b0_uncond  = slot[0].vld && (slot[0].gsel == '0);
  assign b0_dst     = slot[0].dst;
  assign b0_src_val = src_data_i[slot[0].src*DATA_W +: DATA_W];

  // R2: bus 0 unguarded move always lands with its source value
  a_r2_bus0_uncond: assert property (@(posedge clk) disable iff (!rst_sync_n)
    b0_uncond |=> (dst_we_o[$past(b0_dst)] &&
                   (dst_data_o[$past(b0_dst)*DATA_W +: DATA_W] == $past(b0_src_val))));

  // R3: an instruction without valid slots produces no strobe or clash
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !any_vld |=> ((dst_we_o == '0) && !conflict_o));

  // R5: no more strobes than buses
  a_r5_we_bound: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($countones(dst_we_o) <= NUM_BUS));

  // R6: a clash always comes with a delivered write
  a_r6_conflict_has_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    conflict_o |-> (dst_we_o != '0));
endmodule

// File: tb/tport_move_net_tb_top.sv
module tport_move_net_tb_top;
  localparam int NB = 3;
  localparam int DW = 16;
  localparam int SW = 10;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NB*SW-1:0]  move_word;
  logic [8*DW-1:0]   src_data;
  logic [7:0]        dst_we;
  logic [8*DW-1:0]   dst_data;
  logic              conflict;

  int tests = 0;
  int fails = 0;
  int stepn = 0;

  logic [2:0]    mg;
  logic [DW-1:0] mdata [8];

  always #2 clk = ~clk;

  tport_move_net #(.NUM_BUS(NB), .DATA_W(DW)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .move_word_i (move_word),
    .src_data_i  (src_data),
    .dst_we_o    (dst_we),
    .dst_data_o  (dst_data),
    .conflict_o  (conflict)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [9:0] mk(input int v, input int s, input int d,
                                    input int g, input int i);
    return {1'(v), 3'(s), 3'(d), 2'(g), 1'(i)};
  endfunction

  function automatic logic [NB*SW-1:0] on_bus(input int b, input logic [9:0] sl);
    logic [NB*SW-1:0] w = '0;
    w[b*SW +: SW] = sl;
    return w;
  endfunction

  function automatic logic [8*DW-1:0] gen_src(input int n);
    logic [8*DW-1:0] v;
    for (int s = 0; s < 8; s++) v[s*DW +: DW] = 16'(n*40503 + s*9973 + (n >> 2)*7 + 1);
    return v;
  endfunction

  // drive one instruction at a falling edge, check outputs one edge later
  task automatic step(input logic [NB*SW-1:0] w, input logic [8*DW-1:0] sd,
                      input string tag);
    logic [7:0]    ewe = '0;
    logic          econf = 1'b0;
    logic [2:0]    ng = mg;
    logic [DW-1:0] nd [8];
    for (int d = 0; d < 8; d++) nd[d] = mdata[d];
    stepn++;
    move_word = w;
    src_data  = sd;
    for (int b = 0; b < NB; b++) begin
      logic [9:0] sl = w[b*SW +: SW];
      int s  = int'(sl[8:6]);
      int d  = int'(sl[5:3]);
      int gs = int'(sl[2:1]);
      bit go = (gs == 0) ? 1'b1 : (mg[gs-1] ^ sl[0]);
      if (sl[9] && go) begin
        if (ewe[d]) econf = 1'b1;
        else begin
          ewe[d] = 1'b1;
          nd[d]  = sd[s*DW +: DW];
          if (d >= 5) ng[d-5] = sd[s*DW];
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(dst_we == ewe, tag, "strobes", longint'(dst_we), longint'(ewe));
    chk(conflict == econf, tag, "conflict", longint'(conflict), longint'(econf));
    for (int d = 0; d < 8; d++)
      chk(dst_data[d*DW +: DW] == nd[d], tag, $sformatf("data[%0d]", d),
          longint'(dst_data[d*DW +: DW]), longint'(nd[d]));
    mg = ng;
    for (int d = 0; d < 8; d++) mdata[d] = nd[d];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [8*DW-1:0] sd;
    rst_n     = 1'b0;
    move_word = '0;
    src_data  = gen_src(0);
    mg        = '0;
    for (int d = 0; d < 8; d++) mdata[d] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(dst_we == 8'h00, "R1", "strobes in reset", longint'(dst_we), 0);
    chk(conflict == 1'b0, "R1", "conflict in reset", longint'(conflict), 0);
    chk(dst_data == '0, "R1", "data in reset", longint'(dst_data[63:0]), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dst_we == 8'h00, "R1", "strobes after release", longint'(dst_we), 0);
    // R1: guards start at zero, so a plain guarded move is squashed
    step(on_bus(0, mk(1, 2, 1, 1, 0)), gen_src(stepn), "R1");
    step(on_bus(2, mk(1, 3, 2, 3, 1)), gen_src(stepn), "R1");

    // R2: every bus, source and destination, unguarded
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < 8; s++)
        for (int d = 0; d < 8; d++)
          step(on_bus(b, mk(1, s, d, 0, (s + d) & 1)), gen_src(stepn), "R2");

    // R3: invalid slots with busy fields do nothing
    for (int b = 0; b < NB; b++)
      for (int k = 0; k < 8; k++)
        step(on_bus(b, mk(0, k, 7 - k, k & 3, k & 1)), gen_src(stepn), "R3");
    step({mk(0, 1, 5, 0, 0), mk(0, 2, 6, 0, 1), mk(0, 3, 7, 2, 1)},
         gen_src(stepn), "R3");

    // R4 with R7: every guard pattern, select, invert and bus
    for (int gv = 0; gv < 8; gv++) begin
      sd = gen_src(stepn);
      for (int g = 0; g < 3; g++) sd[g*DW] = 1'(gv >> g);
      step({mk(1, 2, 7, 0, 0), mk(1, 1, 6, 0, 0), mk(1, 0, 5, 0, 0)}, sd, "R7");
      for (int gs = 1; gs <= 3; gs++)
        for (int inv = 0; inv < 2; inv++)
          for (int b = 0; b < NB; b++)
            step(on_bus(b, mk(1, (gs + b + inv) % 8, (b + gs) % 5, gs, inv)),
                 gen_src(stepn), "R4");
    end

    // R7: same-edge guard write is not yet visible, next edge it is
    for (int k = 0; k < 4; k++) begin
      sd = gen_src(stepn);
      sd[4*DW] = ~mg[0];
      step({mk(0, 0, 0, 0, 0), mk(1, 4, 5, 0, 0), mk(1, 1, 2, 1, 0)}, sd, "R7");
      step(on_bus(0, mk(1, 3, 1, 1, 0)), gen_src(stepn), "R7");
    end

    // R5: three distinct destinations together
    for (int k = 0; k < 8; k++)
      step({mk(1, (k + 2) % 8, (k + 3) % 8, 0, 0),
            mk(1, (k + 1) % 8, (k + 1) % 8, 0, 1),
            mk(1, k, k, 0, 0)}, gen_src(stepn), "R5");

    // R6: clashes on every destination, with the lower bus sometimes squashed
    for (int d = 0; d < 8; d++) begin
      step({mk(0, 0, 0, 0, 0), mk(1, 5, d, 0, 0), mk(1, 1, d, 0, 0)}, gen_src(stepn), "R6");
      step({mk(1, 6, d, 0, 0), mk(0, 0, 0, 0, 0), mk(1, 2, d, 0, 0)}, gen_src(stepn), "R6");
      step({mk(1, 7, d, 0, 0), mk(1, 4, d, 0, 0), mk(0, 0, 0, 0, 0)}, gen_src(stepn), "R6");
      step({mk(1, 0, d, 0, 0), mk(1, 3, d, 0, 0), mk(1, 6, d, 0, 0)}, gen_src(stepn), "R6");
      step({mk(1, 4, d, 0, 0), mk(1, 2, d, 1, 0), mk(1, 7, d, 1, 1)}, gen_src(stepn), "R6");
    end

    // R8: idle cycles keep every port's data
    for (int k = 0; k < 4; k++) step('0, gen_src(stepn), "R8");

    // R4, R6, R7 mixed: pseudo-random instructions
    for (int k = 0; k < 1500; k++)
      step((NB*SW)'({$urandom, $urandom}), gen_src(stepn), "R4/R6/R7");

    step('0, gen_src(stepn), "R8");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule